// File: doc/BRIEF.md
# Counted-Loop Branch and Stage Predicate Controller

This block carries out the closing branch of a software-pipelined counted loop. It holds a loop counter, an epilogue counter and a 64-bit predicate image. The upper part of the image, from bit 16 up, is a rotating window of stage-enable predicates. Each branch request either continues the loop (loop-top kind) or leaves it (loop-exit kind, opposite sense). For each request the block decides whether the branch is taken and updates the counters. It also tells the register file to rotate, and at the same moment pushes a fresh enable bit into the first-stage predicate.

Software sets up a loop of N iterations over S pipeline stages. It loads the loop counter with N-1, the epilogue counter with S, and a predicate image in which bit 16 is the only rotating bit set. One kernel instruction group, guarded by predicates 16+k for stage k, is then repeated. The single branch makes a prologue that fills the pipeline, a steady kernel, and an epilogue that drains it, for N+S-1 passes in total. The counters and the predicate image are loaded and read through plain word ports.

Top module: `loop_branch_ctrl`

## Requirements
- R1: After reset the loop counter and epilogue counter read 0, the predicate image reads 64'h1, and `br_taken` and `rot_strobe` are low.
- R2: A request while the loop counter is nonzero rotates, writes 1 into predicate bit 16 and lowers the loop counter by one. The epilogue counter is left as it is, and for loop-top kind the branch is taken.
- R3: A request while the loop counter is zero and the epilogue counter is nonzero rotates, writes 0 into predicate bit 16 and lowers the epilogue counter by one. For loop-top kind the branch is taken only if the lowered epilogue count is nonzero. Neither counter ever goes below zero.
- R4: A request while both counters are zero does not rotate, leaves both counters and the predicate image unchanged, and is not taken for loop-top kind.
- R5: A rotation moves each bit n of the image, for n from 16 to 62, into bit n+1. The old bit 63 is dropped and bits 1 to 15 are unchanged.
- R6: `br_kind` = 0 selects loop-top and `br_kind` = 1 selects loop-exit. Loop-exit applies the same counter and predicate updates as loop-top, and its `br_taken` is the inverse of the loop-top decision.
- R7: `br_taken` and `rot_strobe` are registered. They reflect a request in the cycle after it is presented and are low after any cycle without a request. A cycle without a request or a write changes no state.
- R8: The predicate image is written and read as one 64-bit word. Bit 0 always reads 1, whatever is written.
- R9: A load of a counter or of the predicate image in the same cycle as a request takes precedence over that request's update of the same register. The request's other updates and outputs still take place.
- R10: With the loop counter loaded with N-1, the epilogue counter with S, and only bit 16 set in the rotating range, loop-top requests are taken N+S-2 times and then not taken, for N+S-1 passes. Across those passes each stage predicate 16+k, for k below S, is set in exactly N of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lc_we | input | 1 | Load the loop counter |
| lc_wdata | input | 64 | Loop counter load value |
| lc_rdata | output | 64 | Current loop counter |
| ec_we | input | 1 | Load the epilogue counter |
| ec_wdata | input | 6 | Epilogue counter load value |
| ec_rdata | output | 6 | Current epilogue counter |
| pr_we | input | 1 | Load the predicate image |
| pr_wdata | input | 64 | Predicate image load value |
| pr_rdata | output | 64 | Current predicate image, bit 0 forced to 1 |
| br_valid | input | 1 | Branch request this cycle |
| br_kind | input | 1 | 0 = loop-top, 1 = loop-exit |
| br_taken | output | 1 | Registered branch decision |
| rot_strobe | output | 1 | Registered rotate strobe to the register file |

## Verification
The assertions on counter decrements and predicate shifts take for granted that a request does not meet a load of the same register. They are guarded by the write enables, so a cycle that has both is skipped rather than checked. The assertions also assume `br_kind` is a clean 0 or 1 whenever `br_valid` is high. The stimulus drives every input from defined values at the falling edge. Loads and requests are mixed in one cycle only in the dedicated precedence case. Every other request runs from counters loaded in an earlier cycle, so each update seen at the ports comes from exactly one cause.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

   typedef enum logic {
      BR_LOOP_TOP  = 1'b0,
      BR_LOOP_EXIT = 1'b1
   } br_kind_e;

   // per-request action chosen by the decision logic
   typedef struct packed {
      logic rotate;     // shift the predicate window one place
      logic inject;     // value entering the first stage predicate
      logic lc_dec;     // lower the loop counter
      logic ec_dec;     // lower the epilogue counter
      logic top_taken;  // decision in loop-top sense
   } br_action_t;

endpackage

// File: rtl/lbc_decide.sv
module lbc_decide
   import lbc_pkg::*;
(
   input  logic       req_valid,
   input  logic       lc_zero,
   input  logic       ec_zero,
   input  logic       ec_one,
   output br_action_t act
);

   always_comb begin
      act = '0;
      if (req_valid) begin
         if (!lc_zero) begin
            // kernel and prologue: keep feeding new iterations
            act.rotate    = 1'b1;
            act.inject    = 1'b1;
            act.lc_dec    = 1'b1;
            act.top_taken = 1'b1;
         end else if (!ec_zero) begin
            // epilogue: drain, taken while stages remain after this one
            act.rotate    = 1'b1;
            act.inject    = 1'b0;
            act.ec_dec    = 1'b1;
            act.top_taken = !ec_one;
         end
      end
   end

endmodule

// File: rtl/lbc_counters.sv
module lbc_counters #(
   parameter int LC_W = 64,
   parameter int EC_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lc_we,
   input  logic [LC_W-1:0] lc_wdata,
   input  logic            ec_we,
   input  logic [EC_W-1:0] ec_wdata,
   input  logic            lc_dec,
   input  logic            ec_dec,
   output logic [LC_W-1:0] lc_q,
   output logic [EC_W-1:0] ec_q,
   output logic            lc_zero,
   output logic            ec_zero,
   output logic            ec_one
);

   localparam logic [LC_W-1:0] LC_ONE = {{(LC_W-1){1'b0}}, 1'b1};
   localparam logic [EC_W-1:0] EC_ONE = {{(EC_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lc_q <= '0;
      end else if (lc_we) begin
         lc_q <= lc_wdata;
      end else if (lc_dec) begin
         lc_q <= lc_q - LC_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ec_q <= '0;
      end else if (ec_we) begin
         ec_q <= ec_wdata;
      end else if (ec_dec) begin
         ec_q <= ec_q - EC_ONE;
      end
   end

   assign lc_zero = (lc_q == '0);
   assign ec_zero = (ec_q == '0);
   assign ec_one  = (ec_q == EC_ONE);

   assert_lc_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_dec && !lc_we) |=> (lc_q == $past(lc_q) - LC_ONE));

   assert_lc_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lc_dec |-> !lc_zero);

   assert_ec_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ec_dec |-> !ec_zero);

   assert_ec_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ec_dec && !ec_we) |=> (ec_q == $past(ec_q) - EC_ONE));

   assert_ec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_dec && !ec_we) |=> $stable(ec_q));

   assert_one_counter_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(lc_dec && ec_dec));

endmodule

// File: rtl/lbc_pred_file.sv
module lbc_pred_file #(
   parameter int PR_W     = 64,
   parameter int ROT_BASE = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pr_we,
   input  logic [PR_W-1:0] pr_wdata,
   input  logic            rotate,
   input  logic            inject,
   output logic [PR_W-1:0] pr_rdata
);

   localparam int STORE_W = PR_W - 1;   // bit 0 is a constant one

   logic [PR_W-1:1] pr_q;
   logic [PR_W-1:1] rot_next;

   genvar gi;
   generate
      for (gi = 1; gi < PR_W; gi++) begin : g_bit
         if (gi < ROT_BASE) begin : g_static
            assign rot_next[gi] = pr_q[gi];
         end else if (gi == ROT_BASE) begin : g_first
            assign rot_next[gi] = inject;
         end else begin : g_shift
            assign rot_next[gi] = pr_q[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pr_q <= '0;
      end else if (pr_we) begin
         pr_q <= pr_wdata[PR_W-1:1];
      end else if (rotate) begin
         pr_q <= rot_next;
      end
   end

   assign pr_rdata = {pr_q, 1'b1};

   assert_inject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rotate && !pr_we) |=> (pr_rdata[ROT_BASE] == $past(inject)));

   assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rotate && !pr_we) |=>
         (pr_rdata[PR_W-1:ROT_BASE+1] == $past(pr_rdata[PR_W-2:ROT_BASE])));

   assert_low_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pr_we |=> (pr_rdata[ROT_BASE-1:0] == $past(pr_rdata[ROT_BASE-1:0])));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rotate && !pr_we) |=> $stable(pr_rdata));

   initial begin
      assert_width_R8: assert (STORE_W >= ROT_BASE + 1);
   end

endmodule

// File: rtl/loop_branch_ctrl.sv
module loop_branch_ctrl
   import lbc_pkg::*;
#(
   parameter int LC_W     = 64,
   parameter int EC_W     = 6,
   parameter int PR_W     = 64,
   parameter int ROT_BASE = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lc_we,
   input  logic [LC_W-1:0] lc_wdata,
   output logic [LC_W-1:0] lc_rdata,
   input  logic            ec_we,
   input  logic [EC_W-1:0] ec_wdata,
   output logic [EC_W-1:0] ec_rdata,
   input  logic            pr_we,
   input  logic [PR_W-1:0] pr_wdata,
   output logic [PR_W-1:0] pr_rdata,
   input  logic            br_valid,
   input  logic            br_kind,
   output logic            br_taken,
   output logic            rot_strobe
);

   generate
      if (LC_W < 1) begin : g_bad_lc
         $error("LC_W must be at least 1");
      end
      if (EC_W < 2) begin : g_bad_ec
         $error("EC_W must be at least 2");
      end
      if (ROT_BASE < 1 || ROT_BASE > PR_W - 2) begin : g_bad_rot
         $error("ROT_BASE must leave room for a rotating window");
      end
   endgenerate

   br_kind_e   kind;
   br_action_t act;
   logic       lc_zero, ec_zero, ec_one;
   logic       taken_q, rot_q;

   assign kind = br_kind_e'(br_kind);

   lbc_decide u_decide (
      .req_valid (br_valid),
      .lc_zero   (lc_zero),
      .ec_zero   (ec_zero),
      .ec_one    (ec_one),
      .act       (act)
   );

   lbc_counters #(.LC_W(LC_W), .EC_W(EC_W)) u_counters (
      .clk      (clk),
      .rst_n    (rst_n),
      .lc_we    (lc_we),
      .lc_wdata (lc_wdata),
      .ec_we    (ec_we),
      .ec_wdata (ec_wdata),
      .lc_dec   (act.lc_dec),
      .ec_dec   (act.ec_dec),
      .lc_q     (lc_rdata),
      .ec_q     (ec_rdata),
      .lc_zero  (lc_zero),
      .ec_zero  (ec_zero),
      .ec_one   (ec_one)
   );

   lbc_pred_file #(.PR_W(PR_W), .ROT_BASE(ROT_BASE)) u_pred (
      .clk      (clk),
      .rst_n    (rst_n),
      .pr_we    (pr_we),
      .pr_wdata (pr_wdata),
      .rotate   (act.rotate),
      .inject   (act.inject),
      .pr_rdata (pr_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q <= 1'b0;
         rot_q   <= 1'b0;
      end else begin
         rot_q   <= act.rotate;
         taken_q <= br_valid &&
                    ((kind == BR_LOOP_EXIT) ? !act.top_taken : act.top_taken);
      end
   end

   assign br_taken   = taken_q;
   assign rot_strobe = rot_q;

   assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid |=> (!br_taken && !rot_strobe));

   assert_top_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !br_kind && (lc_rdata != '0)) |=> (br_taken && rot_strobe));

   assert_exit_inv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_kind && (lc_rdata != '0)) |=> (!br_taken && rot_strobe));

   assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && (lc_rdata == '0) && (ec_rdata == '0) && !lc_we && !ec_we)
      |=> (!rot_strobe && $stable(lc_rdata) && $stable(ec_rdata)));

   assert_bit0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pr_we) |-> pr_rdata[0]);

endmodule

// File: tb/loop_branch_ctrl_tb.sv
module loop_branch_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      int          due;
      bit          taken;
      bit          rot;
      logic [63:0] lc;
      logic [5:0]  ec;
      logic [63:0] pr;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lc_we = 1'b0, ec_we = 1'b0, pr_we = 1'b0;
   logic [63:0] lc_wdata = '0, pr_wdata = '0;
   logic [5:0]  ec_wdata = '0;
   logic [63:0] lc_rdata, pr_rdata;
   logic [5:0]  ec_rdata;
   logic        br_valid = 1'b0, br_kind = 1'b0;
   logic        br_taken, rot_strobe;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   exp_t sb[$];

   logic [63:0] m_lc = '0;
   logic [5:0]  m_ec = '0;
   logic [63:0] m_pr = 64'h1;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   loop_branch_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .lc_we(lc_we), .lc_wdata(lc_wdata), .lc_rdata(lc_rdata),
      .ec_we(ec_we), .ec_wdata(ec_wdata), .ec_rdata(ec_rdata),
      .pr_we(pr_we), .pr_wdata(pr_wdata), .pr_rdata(pr_rdata),
      .br_valid(br_valid), .br_kind(br_kind),
      .br_taken(br_taken), .rot_strobe(rot_strobe)
   );

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: compare queued expectations when they fall due
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due == cyc) begin
         exp_t e;
         e = sb.pop_front();
         check(e.req, "br_taken",   {63'b0, br_taken},   {63'b0, e.taken});
         check(e.req, "rot_strobe", {63'b0, rot_strobe}, {63'b0, e.rot});
         check(e.req, "lc",         lc_rdata,            e.lc);
         check(e.req, "ec",         {58'b0, ec_rdata},   {58'b0, e.ec});
         check(e.req, "pr",         pr_rdata,            e.pr);
      end
   end

   // driver: one cycle of stimulus, model update, push expectation
   task automatic drive(bit v, bit k, bit lwe, logic [63:0] lwd,
                        bit ewe, logic [5:0] ewd, bit pwe, logic [63:0] pwd,
                        string req);
      exp_t e;
      bit rot = 0, inj = 0, tt = 0;
      logic [63:0] n_lc = m_lc, n_pr = m_pr;
      logic [5:0]  n_ec = m_ec;
      br_valid = v; br_kind = k;
      lc_we = lwe; lc_wdata = lwd;
      ec_we = ewe; ec_wdata = ewd;
      pr_we = pwe; pr_wdata = pwd;
      if (v) begin
         if (m_lc != 0) begin
            rot = 1; inj = 1; tt = 1; n_lc = m_lc - 1;
         end else if (m_ec != 0) begin
            rot = 1; inj = 0; tt = (m_ec != 1); n_ec = m_ec - 1;
         end
      end
      if (rot) begin
         for (int i = 63; i > 16; i--) n_pr[i] = m_pr[i-1];
         n_pr[16] = inj;
      end
      if (lwe) n_lc = lwd;
      if (ewe) n_ec = ewd;
      if (pwe) n_pr = {pwd[63:1], 1'b1};
      m_lc = n_lc; m_ec = n_ec; m_pr = n_pr;
      e.due = cyc + 1;
      e.taken = v && (k ? !tt : tt);
      e.rot = rot;
      e.lc = m_lc; e.ec = m_ec; e.pr = m_pr;
      e.req = req;
      sb.push_back(e);
      @(negedge clk);
      br_valid = 0; lc_we = 0; ec_we = 0; pr_we = 0;
   endtask

   task automatic branch(bit k, string req);
      drive(1, k, 0, '0, 0, '0, 0, '0, req);
   endtask

   task automatic setup(logic [63:0] lc, logic [5:0] ec, logic [63:0] pr, string req);
      drive(0, 0, 1, lc, 1, ec, 1, pr, req);
   endtask

   // run a full pipelined loop and count passes and stage enables
   task automatic run_loop(int n, int s);
      int passes = 0;
      int stage_cnt[8];
      bit t;
      foreach (stage_cnt[i]) stage_cnt[i] = 0;
      setup(64'(n - 1), 6'(s), 64'h1 << 16, "R10");
      do begin
         for (int k = 0; k < s; k++) if (pr_rdata[16+k]) stage_cnt[k]++;
         branch(0, "R10");
         t = br_taken;
         passes++;
      end while (t && passes < 5000);
      check("R10", "passes", 64'(passes), 64'(n + s - 1));
      for (int k = 0; k < s; k++)
         check("R10", "stage enables", 64'(stage_cnt[k]), 64'(n));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "lc", lc_rdata, 64'h0);
      check("R1", "ec", {58'b0, ec_rdata}, 64'h0);
      check("R1", "pr", pr_rdata, 64'h1);
      check("R1", "taken", {63'b0, br_taken}, 64'h0);
      check("R1", "rot", {63'b0, rot_strobe}, 64'h0);

      // R4 both counters zero, loop-top and loop-exit
      branch(0, "R4");
      branch(1, "R6");

      // R8 bit 0 forced, static low bits kept across rotation (R5)
      setup(64'h2, 6'd2, 64'h8000_0000_0001_A0A4 ^ 64'h0, "R8");
      setup(64'h2, 6'd2, 64'hC000_0000_0001_7FFE, "R8");
      branch(0, "R2");
      branch(0, "R5");
      branch(0, "R3");
      branch(0, "R3");
      branch(0, "R4");

      // R7 idle cycles change nothing and keep outputs low
      drive(0, 0, 0, '0, 0, '0, 0, '0, "R7");
      drive(0, 1, 0, '0, 0, '0, 0, '0, "R7");

      // R6 loop-exit through kernel and epilogue
      setup(64'h1, 6'd2, 64'h0001_0000, "R6");
      branch(1, "R6");
      branch(1, "R6");
      branch(1, "R6");
      branch(1, "R6");

      // R2 largest loop count
      setup(64'hFFFF_FFFF_FFFF_FFFF, 6'd63, 64'hFFFF_0000_0000_0000, "R2");
      branch(0, "R2");
      // R3 epilogue with largest epilogue count
      setup(64'h0, 6'd63, 64'h5555_5555_5555_5554, "R3");
      branch(0, "R3");
      branch(1, "R3");

      // R9 loads win over the same request's update
      setup(64'h3, 6'd2, 64'h0003_0000, "R9");
      drive(1, 0, 1, 64'd10, 0, '0, 0, '0, "R9");
      drive(1, 0, 0, '0, 1, 6'd7, 1, 64'h0, "R9");
      setup(64'h0, 6'd1, 64'h0, "R9");
      drive(1, 0, 0, '0, 1, 6'd5, 0, '0, "R9");

      // R10 full loops
      run_loop(5, 3);
      run_loop(1, 2);
      run_loop(2000, 4);

      repeat (3) @(negedge clk);
      check("R7", "scoreboard drained", 64'(sb.size()), 64'h0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule